// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block steers a dual-modulus prescaler in a frequency-synthesis loop so that the loop divides by a non-integer ratio. On every comparison cycle it adds a fractional step Q to a phase accumulator. The accumulator wraps at a fixed modulus of 223, which is not a power of two. A cycle in which the accumulator reaches or passes 223 divides by P+1 and keeps the excess. Every other cycle divides by P. Averaged over time, the division ratio is P + Q/223.

The block also holds the programmable counter that divides the incoming clock by the modulus chosen for the current cycle. It emits one single-clock pulse at the end of each comparison cycle. The integer part arrives as a 4-bit code equal to 16 − P, so code 9 selects P = 7 and code 0 selects P = 16. The fractional part arrives as an 8-bit code. New codes are taken only at a cycle boundary. A fractional code at or above the modulus is clamped to 222, and a flag reports the clamp.

Top module: `fracn_divctl`

## Requirements
- R1: While `rst` is high, and in the clock after it is sampled high, `cyc_pulse`, `mod_plus1` and `frac_clamped` are all 0. Reset also clears the phase accumulator to 0.
- R2: The integer code c selects P = 16 − c, and c = 0 selects P = 16. A comparison cycle with `mod_plus1` low lasts exactly P input clocks. A cycle with `mod_plus1` high lasts P+1 input clocks.
- R3: At each boundary the fractional step is added to the accumulator. If the sum is 223 or more, the new cycle has `mod_plus1` = 1 and the accumulator keeps sum − 223. Otherwise `mod_plus1` = 0 and the accumulator keeps the sum. Starting from reset with Q = 159, the first four cycles therefore show `mod_plus1` = 0, 1, 1, 0.
- R4: Any 223 consecutive comparison cycles span exactly 223·P + Q input clocks.
- R5: A fractional code of 223 or above is used as 222, and `frac_clamped` is 1 for the cycle that used it. A code of 222 or below is used as is, and the flag is 0.
- R6: Changes to `int_code` or `frac_code` in the middle of a cycle leave that cycle's length unchanged. The new values are first used in the cycle that starts at the next boundary.
- R7: `cyc_pulse` is high for exactly one clock, the last clock of each comparison cycle. The first cycle after reset starts at the first clock edge with `rst` low and emits no pulse at its start. `mod_plus1` and `frac_clamped` change only at a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| int_code | input | 4 | Integer part written as 16 − P (0 means P = 16) |
| frac_code | input | 8 | Fractional step Q; 223 and above are clamped |
| cyc_pulse | output | 1 | One-clock pulse in the last clock of each comparison cycle |
| mod_plus1 | output | 1 | High when the current cycle divides by P+1 |
| frac_clamped | output | 1 | High when the current cycle used a clamped fractional step |

## Verification
The checker assumes that `int_code` and `frac_code` are stable at each boundary edge. It also assumes that reset is held for at least one edge before any cycle-length check begins. The bench changes its codes only at falling clock edges, so every boundary edge sees settled values. In the one test that changes a code mid-cycle, the change is made at a falling edge well away from the boundary. That test shows the running cycle is unaffected and the following cycle takes the new value.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } mod_sel_e;

    // Integer part is written as (2**int_w - P); a code of zero means P = 2**int_w.
    function automatic int unsigned p_of_code(input int unsigned code, input int unsigned int_w);
        int unsigned full;
        full = 32'd1 << int_w;
        return (code == 0) ? full : (full - code);
    endfunction

endpackage

// File: rtl/fdiv_cfg_decode.sv
module fdiv_cfg_decode #(
    parameter int INT_W   = 4,
    parameter int FRAC_W  = 8,
    parameter int MODULUS = 223,
    localparam int LEN_W  = INT_W + 1
) (
    input  logic [INT_W-1:0]  int_code,
    input  logic [FRAC_W-1:0] frac_code,
    output logic [LEN_W-1:0]  p_len,
    output logic [FRAC_W-1:0] q_eff,
    output logic              q_over
);
    localparam logic [FRAC_W:0]   MOD_WIDE = (FRAC_W+1)'(MODULUS);
    localparam logic [FRAC_W-1:0] Q_MAX    = FRAC_W'(MODULUS - 1);

    always_comb begin
        p_len  = LEN_W'(fdiv_pkg::p_of_code(int_code, INT_W));
        q_over = ({1'b0, frac_code} >= MOD_WIDE);
        q_eff  = q_over ? Q_MAX : frac_code;
    end
endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
    parameter int FRAC_W  = 8,
    parameter int MODULUS = 223,
    localparam int ACC_W  = $clog2(MODULUS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [FRAC_W-1:0] q_eff,
    output logic              carry,
    output logic [ACC_W-1:0]  acc_q
);
    localparam logic [ACC_W:0] MOD_V = (ACC_W+1)'(MODULUS);

    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_next;

    always_comb begin
        sum      = {1'b0, acc_q} + (ACC_W+1)'(q_eff);
        carry    = (sum >= MOD_V);
        acc_next = carry ? ACC_W'(sum - MOD_V) : ACC_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_next;
        end
    end
endmodule

// File: rtl/fdiv_mod_counter.sv
module fdiv_mod_counter #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_next,
    output logic             boundary,
    output logic             pulse
);
    logic [LEN_W-1:0] cnt_q;
    logic             running_q;

    always_comb begin
        boundary = (cnt_q == '0);
        pulse    = boundary && running_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else begin
            running_q <= 1'b1;
            if (boundary) begin
                cnt_q <= len_next - LEN_W'(1);
            end else begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
    parameter int INT_W   = 4,
    parameter int FRAC_W  = 8,
    parameter int MODULUS = 223
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  int_code,
    input  logic [FRAC_W-1:0] frac_code,
    output logic              cyc_pulse,
    output logic              mod_plus1,
    output logic              frac_clamped
);
    import fdiv_pkg::*;

    localparam int LEN_W = INT_W + 1;
    localparam int ACC_W = $clog2(MODULUS);

    logic [LEN_W-1:0]  p_len;
    logic [FRAC_W-1:0] q_eff;
    logic              q_over;
    logic              carry;
    logic [ACC_W-1:0]  acc_val;
    logic              boundary;
    logic [LEN_W-1:0]  len_next;
    mod_sel_e          sel_q;
    logic              clamp_q;

    fdiv_cfg_decode #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MODULUS(MODULUS)) u_dec (
        .int_code (int_code),
        .frac_code(frac_code),
        .p_len    (p_len),
        .q_eff    (q_eff),
        .q_over   (q_over)
    );

    fdiv_phase_acc #(.FRAC_W(FRAC_W), .MODULUS(MODULUS)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .step (boundary),
        .q_eff(q_eff),
        .carry(carry),
        .acc_q(acc_val)
    );

    assign len_next = p_len + LEN_W'(carry);

    fdiv_mod_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .len_next(len_next),
        .boundary(boundary),
        .pulse   (cyc_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= MOD_BASE;
            clamp_q <= 1'b0;
        end else if (boundary) begin
            sel_q   <= carry ? MOD_PLUS1 : MOD_BASE;
            clamp_q <= q_over;
        end
    end

    assign mod_plus1    = (sel_q == MOD_PLUS1);
    assign frac_clamped = clamp_q;
endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
    parameter int INT_W   = 4,
    parameter int FRAC_W  = 8,
    parameter int MODULUS = 223,
    localparam int ACC_W  = $clog2(MODULUS),
    localparam int LEN_W  = INT_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [INT_W-1:0]  int_code,
    input logic [FRAC_W-1:0] frac_code,
    input logic              cyc_pulse,
    input logic              mod_plus1,
    input logic              frac_clamped,
    input logic [ACC_W-1:0]  acc
);
    logic [LEN_W:0]   gap;
    logic [LEN_W-1:0] exp_len;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            exp_len <= '0;
            armed   <= 1'b0;
        end else if (cyc_pulse || !armed) begin
            armed   <= 1'b1;
            gap     <= (LEN_W+1)'(1);
            exp_len <= LEN_W'(fdiv_pkg::p_of_code(int_code, INT_W));
        end else begin
            gap <= gap + (LEN_W+1)'(1);
        end
    end

    // R3
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, acc} < (ACC_W+1)'(MODULUS)));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_pulse && !$past(rst)) |=> ($stable(mod_plus1) && $stable(frac_clamped)));

    // R5
    clamp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_pulse |=> (frac_clamped == ({1'b0, $past(frac_code)} >= (FRAC_W+1)'(MODULUS))));

    // R2
    cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_pulse && armed) |-> (gap == ({1'b0, exp_len} + (LEN_W+1)'(mod_plus1))));
endmodule

bind fracn_divctl fracn_divctl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MODULUS(MODULUS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .int_code    (int_code),
    .frac_code   (frac_code),
    .cyc_pulse   (cyc_pulse),
    .mod_plus1   (mod_plus1),
    .frac_clamped(frac_clamped),
    .acc         (acc_val)
);

// File: tb/sim_fracn_divctl.sv
module sim_fracn_divctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] int_in = 4'd9;
    logic [7:0] frac_in = 8'd0;
    logic       cyc_pulse, mod_plus1, frac_clamped;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    int m_rem = 0, m_acc = 0;
    bit m_started = 0, m_hi = 0, m_err = 0;

    always #5 clk = ~clk;

    fracn_divctl u0 (
        .clk(clk), .rst(rst), .int_code(int_in), .frac_code(frac_in),
        .cyc_pulse(cyc_pulse), .mod_plus1(mod_plus1), .frac_clamped(frac_clamped)
    );

    always @(posedge clk) begin
        int qv, pv;
        cyc++;
        if (rst) begin
            m_started = 0; m_rem = 0; m_acc = 0; m_hi = 0; m_err = 0;
        end else begin
            if (m_rem == 0) begin
                qv = (frac_in > 222) ? 222 : int'(frac_in);
                m_err = (frac_in > 222);
                pv = (int_in == 0) ? 16 : 16 - int'(int_in);
                m_acc = m_acc + qv;
                m_hi = (m_acc >= 223);
                if (m_hi) m_acc = m_acc - 223;
                m_rem = pv + int'(m_hi) - 1;
            end else begin
                m_rem = m_rem - 1;
            end
            m_started = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        bit ep;
        @(negedge clk);
        ep = m_started && (m_rem == 0);
        chk(cyc_pulse == ep, "R7 cyc_pulse vs model", int'(cyc_pulse), int'(ep));
        chk(mod_plus1 == m_hi, "R3 mod_plus1 vs model", int'(mod_plus1), int'(m_hi));
        chk(frac_clamped == m_err, "R5 frac_clamped vs model", int'(frac_clamped), int'(m_err));
    endtask

    task automatic wait_pulse();
        do tick(); while (!cyc_pulse);
    endtask

    task automatic window(input int code, input int q);
        int n, cnt, pv, qv;
        int_in = 4'(code);
        frac_in = 8'(q);
        wait_pulse();
        n = 0; cnt = 0;
        while (n < 223) begin
            tick();
            cnt++;
            if (cyc_pulse) n++;
        end
        pv = (code == 0) ? 16 : 16 - code;
        qv = (q > 222) ? 222 : q;
        chk(cnt == 223 * pv + qv, "R4 clocks over 223 cycles", cnt, 223 * pv + qv);
    endtask

    task automatic flag_case(input int q, input bit exp_flag);
        frac_in = 8'(q);
        wait_pulse();
        tick();
        chk(frac_clamped == exp_flag, "R5 clamp flag", int'(frac_clamped), int'(exp_flag));
    endtask

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit exp_seq[4];
        int g, hi;
        exp_seq = '{0, 1, 1, 0};
        // R1: reset state
        rst = 1'b1; int_in = 4'd9; frac_in = 8'd159;
        repeat (3) tick();
        chk(cyc_pulse == 0, "R1 cyc_pulse in reset", int'(cyc_pulse), 0);
        chk(mod_plus1 == 0, "R1 mod_plus1 in reset", int'(mod_plus1), 0);
        chk(frac_clamped == 0, "R1 frac_clamped in reset", int'(frac_clamped), 0);
        rst = 1'b0;
        // R3: carry pattern from a cleared accumulator with Q=159
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(mod_plus1 == exp_seq[k], "R3 carry sequence", int'(mod_plus1), int'(exp_seq[k]));
            wait_pulse();
        end
        // R4 / R2: example settings and edge integer codes
        window(9, 159);
        window(3, 181);
        window(13, 51);
        window(0, 0);
        window(14, 0);
        window(0, 222);
        // R5: clamping at and around the modulus
        int_in = 4'd9;
        flag_case(222, 0);
        flag_case(223, 1);
        flag_case(255, 1);
        flag_case(100, 0);
        window(9, 255);
        // R6: mid-cycle change affects only the next cycle
        int_in = 4'd9; frac_in = 8'd159;
        wait_pulse();
        tick();
        hi = int'(mod_plus1);
        g = 1;
        tick(); g++;
        int_in = 4'd3;
        do begin tick(); g++; end while (!cyc_pulse);
        chk(g == 7 + hi, "R6 running cycle length kept", g, 7 + hi);
        tick();
        hi = int'(mod_plus1);
        g = 1;
        do begin tick(); g++; end while (!cyc_pulse);
        chk(g == 13 + hi, "R6 R2 next cycle uses new P", g, 13 + hi);
        // R1: reset in mid-run
        rst = 1'b1;
        tick(); tick();
        chk(cyc_pulse == 0 && mod_plus1 == 0 && frac_clamped == 0, "R1 outputs after mid-run reset",
            int'({cyc_pulse, mod_plus1, frac_clamped}), 0);
        rst = 1'b0; int_in = 4'd9; frac_in = 8'd159;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(mod_plus1 == exp_seq[k], "R1 R3 accumulator cleared by reset", int'(mod_plus1), int'(exp_seq[k]));
            wait_pulse();
        end
        window(9, 159);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule